// File: doc/BRIEF.md
# RTC Shadow Register Synchronizer

This block sits between a processor register port and a real-time counter that runs from a slow clock. It keeps a shadow copy of the time value and of the two rate-trim fields. When no freeze is active, the shadow reloads from the live counter on every slow update tick. The processor therefore always reads a recent value. Setting the read-freeze bit stops the reload, so a multi-field read sees one consistent snapshot.

Setting the write-freeze bit opens the shadow to processor writes. When software clears that bit, the staged time and trim values go to the live counter as a one-cycle load pulse on the next slow update tick. The write-freeze status bit keeps reading 1 after software clears it, and drops only once that load has happened. A sticky failure flag records count errors reported by the counter. Only a write of 0 clears it.

The slow update tick arrives as a toggle from the slow domain. The block synchronizes it into the bus clock and turns every edge of the toggle into a single-cycle strobe. The counter itself and any calendar arithmetic live outside the block.

Top module: `rtc_shadow_sync`

## Requirements
- R1: After reset, the control word reads 0, the time and trim shadows read 0, and `load_en` is low.
- R2: With no freeze and no pending load, each update tick copies `live_time`, `live_p` and `live_q` into the shadow. Address 1 returns the time. Address 2 returns the trim word, with P in bits [18:2] and Q in bits [1:0].
- R3: Control bit 0 (read freeze) stops the shadow reloading on ticks and reads back as 1. Once it is cleared, the shadow resumes tracking from the next tick.
- R4: Writes to address 1 or 2 update the shadow only while control bit 1 (write freeze) is set. At any other time they leave the shadow unchanged.
- R5: Clearing control bit 1 arms a transfer. On the first tick that follows, `load_en` pulses for one cycle and carries the shadow time, P and Q. No transfer happens while bit 1 is set.
- R6: Control bit 1 reads 1 from the moment it is written to 1 until the armed transfer completes, even after software has written it to 0.
- R7: Control bit 2 (failure flag) is set by a `count_err` pulse and stays set. Writing 0 to it clears it, and writing 1 has no effect. When `count_err` arrives in the same cycle as a clearing write, the flag ends up set.
- R8: Each transition of `tick_tgl` in either direction counts as exactly one update tick. Its effect is visible after three bus clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 time, 2 trim |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| tick_tgl | input | 1 | Slow-domain update toggle |
| live_time | input | TIME_W | Current counter time |
| live_p | input | P_W | Current trim P |
| live_q | input | Q_W | Current trim Q |
| count_err | input | 1 | Count error pulse from the counter |
| load_en | output | 1 | One-cycle transfer strobe to the counter |
| load_time | output | TIME_W | Time value to load |
| load_p | output | P_W | Trim P to load |
| load_q | output | Q_W | Trim Q to load |

## Verification
The live inputs change value between ticks, so a shadow that tracks can be told apart from one that is stale. The test runs the same change under read freeze, under write freeze and with no freeze. This separates a missed reload from a reload that should have been blocked. Three write cases are compared: a staged write with the freeze set, the same write with the freeze clear, and a tick while the freeze is held. Together they show that writes are gated correctly and that a transfer comes only after the release. A `count_err` pulse that coincides with a clearing write shows which of the two wins on the failure flag.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_TIME = 2'd1,
    ADDR_TRIM = 2'd2
  } rtc_addr_e;

  localparam int CTRL_RD_BIT   = 0;
  localparam int CTRL_WR_BIT   = 1;
  localparam int CTRL_FAIL_BIT = 2;
  localparam int CTRL_BITS     = 3;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_tgl,
  output logic tick_stb
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b0;
          else     sync_q[gi] <= tick_tgl;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b0;
          else     sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign tick_stb = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/rtc_freeze_ctrl.sv
module rtc_freeze_ctrl
  import rtc_shadow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_stb,
  input  logic                 ctrl_we,
  input  logic [CTRL_BITS-1:0] ctrl_wdata,
  input  logic                 count_err,
  output logic                 rd_frz,
  output logic                 wr_frz,
  output logic                 pending,
  output logic                 fail_flag,
  output logic                 reload_en,
  output logic                 commit_en
);
  assign reload_en = tick_stb & ~rd_frz & ~wr_frz & ~pending;
  assign commit_en = tick_stb & pending & ~wr_frz;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_frz  <= 1'b0;
      wr_frz  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (commit_en) pending <= 1'b0;
      if (ctrl_we) begin
        rd_frz <= ctrl_wdata[CTRL_RD_BIT];
        wr_frz <= ctrl_wdata[CTRL_WR_BIT];
        if (wr_frz && !ctrl_wdata[CTRL_WR_BIT]) pending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                        fail_flag <= 1'b0;
    else if (count_err)                             fail_flag <= 1'b1;
    else if (ctrl_we && !ctrl_wdata[CTRL_FAIL_BIT]) fail_flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank #(
  parameter int TIME_W = 32,
  parameter int P_W    = 17,
  parameter int Q_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload_en,
  input  logic              commit_en,
  input  logic              wr_time_en,
  input  logic              wr_trim_en,
  input  logic [TIME_W-1:0] wdata_time,
  input  logic [P_W-1:0]    wdata_p,
  input  logic [Q_W-1:0]    wdata_q,
  input  logic [TIME_W-1:0] live_time,
  input  logic [P_W-1:0]    live_p,
  input  logic [Q_W-1:0]    live_q,
  output logic [TIME_W-1:0] shadow_time,
  output logic [P_W-1:0]    shadow_p,
  output logic [Q_W-1:0]    shadow_q,
  output logic              load_en,
  output logic [TIME_W-1:0] load_time,
  output logic [P_W-1:0]    load_p,
  output logic [Q_W-1:0]    load_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_time <= '0;
      shadow_p    <= '0;
      shadow_q    <= '0;
    end else if (reload_en) begin
      shadow_time <= live_time;
      shadow_p    <= live_p;
      shadow_q    <= live_q;
    end else begin
      if (wr_time_en) shadow_time <= wdata_time;
      if (wr_trim_en) begin
        shadow_p <= wdata_p;
        shadow_q <= wdata_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en   <= 1'b0;
      load_time <= '0;
      load_p    <= '0;
      load_q    <= '0;
    end else begin
      load_en <= commit_en;
      if (commit_en) begin
        load_time <= shadow_time;
        load_p    <= shadow_p;
        load_q    <= shadow_q;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_sync.sv
module rtc_shadow_sync
  import rtc_shadow_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TIME_W      = 32,
  parameter int P_W         = 17,
  parameter int Q_W         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_tgl,
  input  logic [TIME_W-1:0] live_time,
  input  logic [P_W-1:0]    live_p,
  input  logic [Q_W-1:0]    live_q,
  input  logic              count_err,
  output logic              load_en,
  output logic [TIME_W-1:0] load_time,
  output logic [P_W-1:0]    load_p,
  output logic [Q_W-1:0]    load_q
);
  localparam int TRIM_W = P_W + Q_W;

  logic              tick_stb;
  logic              rd_frz, wr_frz, pending, fail_flag;
  logic              reload_en, commit_en;
  logic              ctrl_we, wr_time_en, wr_trim_en;
  logic [TIME_W-1:0] shadow_time;
  logic [P_W-1:0]    shadow_p;
  logic [Q_W-1:0]    shadow_q;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_we    = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_time_en = reg_we && (reg_addr == ADDR_TIME) && wr_frz;
  assign wr_trim_en = reg_we && (reg_addr == ADDR_TRIM) && wr_frz;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .tick_tgl(tick_tgl), .tick_stb(tick_stb)
  );

  rtc_freeze_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick_stb(tick_stb), .ctrl_we(ctrl_we),
    .ctrl_wdata(reg_wdata[CTRL_BITS-1:0]), .count_err(count_err),
    .rd_frz(rd_frz), .wr_frz(wr_frz), .pending(pending),
    .fail_flag(fail_flag), .reload_en(reload_en), .commit_en(commit_en)
  );

  rtc_shadow_bank #(.TIME_W(TIME_W), .P_W(P_W), .Q_W(Q_W)) u_bank (
    .clk(clk), .rst(rst), .reload_en(reload_en), .commit_en(commit_en),
    .wr_time_en(wr_time_en), .wr_trim_en(wr_trim_en),
    .wdata_time(reg_wdata[TIME_W-1:0]),
    .wdata_p(reg_wdata[TRIM_W-1:Q_W]), .wdata_q(reg_wdata[Q_W-1:0]),
    .live_time(live_time), .live_p(live_p), .live_q(live_q),
    .shadow_time(shadow_time), .shadow_p(shadow_p), .shadow_q(shadow_q),
    .load_en(load_en), .load_time(load_time), .load_p(load_p), .load_q(load_q)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        rd_mux[CTRL_RD_BIT]   = rd_frz;
        rd_mux[CTRL_WR_BIT]   = wr_frz | pending;
        rd_mux[CTRL_FAIL_BIT] = fail_flag;
      end
      ADDR_TIME: rd_mux = DATA_W'(shadow_time);
      ADDR_TRIM: rd_mux = DATA_W'({shadow_p, shadow_q});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_shadow_sync_chk.sv
module rtc_shadow_sync_chk #(
  parameter int TIME_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_stb,
  input logic              rd_frz,
  input logic              wr_frz,
  input logic              pending,
  input logic              fail_flag,
  input logic              wr_time_en,
  input logic              count_err,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [TIME_W-1:0] shadow_time,
  input logic              load_en
);
  // R5
  single_commit_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !load_en);

  // R5
  commit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> ($past(tick_stb) && !$past(wr_frz)));

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_frz) && !$past(wr_time_en)) |-> $stable(shadow_time));

  // R6
  pending_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_frz) |-> pending);

  // R7
  err_sets_fail_chk: assert property (@(posedge clk) disable iff (rst)
    count_err |=> fail_flag);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && !(reg_we && reg_addr == 2'd0 && !reg_wdata[2])) |=> fail_flag);
endmodule

bind rtc_shadow_sync rtc_shadow_sync_chk #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick_stb(tick_stb), .rd_frz(rd_frz), .wr_frz(wr_frz),
  .pending(pending), .fail_flag(fail_flag), .wr_time_en(wr_time_en),
  .count_err(count_err), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .shadow_time(shadow_time), .load_en(load_en)
);

// File: tb/rtc_shadow_sync_bench.sv
module rtc_shadow_sync_bench;
  localparam int DATA_W = 32;
  localparam int TIME_W = 32;
  localparam int P_W    = 17;
  localparam int Q_W    = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              tick_tgl = 1'b0;
  logic [TIME_W-1:0] live_time = '0;
  logic [P_W-1:0]    live_p = '0;
  logic [Q_W-1:0]    live_q = '0;
  logic              count_err = 1'b0;
  logic              load_en;
  logic [TIME_W-1:0] load_time;
  logic [P_W-1:0]    load_p;
  logic [Q_W-1:0]    load_q;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  rtc_shadow_sync u_rtc_shadow_sync (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_tgl(tick_tgl),
    .live_time(live_time), .live_p(live_p), .live_q(live_q),
    .count_err(count_err), .load_en(load_en), .load_time(load_time),
    .load_p(load_p), .load_q(load_q)
  );

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;

  typedef struct {
    logic [TIME_W-1:0] t;
    logic [P_W-1:0]    p;
    logic [Q_W-1:0]    q;
  } ld_item_t;

  rd_item_t rd_q[$];
  ld_item_t ld_q[$];
  logic     rd_go = 1'b0;

  // Read monitor: compares the registered read data with the queued expectation.
  always @(negedge clk) begin
    if (rd_go) begin
      rd_item_t it;
      it = rd_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
      end
      rd_go = 1'b0;
    end
  end

  // Transfer monitor: every load pulse must match a queued transfer (R5).
  always @(negedge clk) begin
    if (!rst && load_en) begin
      checks++;
      if (ld_q.size() == 0) begin
        errors++;
        $display("FAIL R5: unexpected load time=%h p=%h q=%h expected no load",
                 load_time, load_p, load_q);
      end else begin
        ld_item_t li;
        li = ld_q.pop_front();
        if (load_time !== li.t || load_p !== li.p || load_q !== li.q) begin
          errors++;
          $display("FAIL R5: load time=%h p=%h q=%h expected time=%h p=%h q=%h",
                   load_time, load_p, load_q, li.t, li.p, li.q);
        end
      end
    end
  end

  task automatic do_read(input logic [1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    reg_addr = a;
    it.exp = e;
    it.tag = tag;
    rd_q.push_back(it);
    @(posedge clk);
    #1ns rd_go = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_tgl = ~tick_tgl;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_load(input logic [TIME_W-1:0] t, input logic [P_W-1:0] p,
                             input logic [Q_W-1:0] q);
    ld_item_t li;
    li.t = t; li.p = p; li.q = q;
    ld_q.push_back(li);
  endtask

  function automatic logic [DATA_W-1:0] trim_word(input logic [P_W-1:0] p, input logic [Q_W-1:0] q);
    return DATA_W'({p, q});
  endfunction

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: run did not finish expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    checks++;
    if (load_en !== 1'b0) begin
      errors++;
      $display("FAIL R1: load_en=%b expected=0", load_en);
    end
    do_read(2'd0, 32'h0, "R1 ctrl");
    do_read(2'd1, 32'h0, "R1 time");
    do_read(2'd2, 32'h0, "R1 trim");

    // R2 / R8 tracking on rising and falling toggle edges
    live_time = 32'h0000_1234; live_p = 17'h10000; live_q = 2'd1;
    do_tick();
    do_read(2'd1, 32'h0000_1234, "R2 R8 time rise");
    do_read(2'd2, trim_word(17'h10000, 2'd1), "R2 trim");
    live_time = 32'h0000_ABCD;
    do_tick();
    do_read(2'd1, 32'h0000_ABCD, "R2 R8 time fall");

    // R3 read freeze
    do_write(2'd0, 32'h1);
    do_read(2'd0, 32'h1, "R3 ctrl freeze");
    live_time = 32'h0000_5555;
    do_tick();
    do_read(2'd1, 32'h0000_ABCD, "R3 held");
    do_write(2'd0, 32'h0);
    do_read(2'd0, 32'h0, "R3 ctrl cleared");
    do_tick();
    do_read(2'd1, 32'h0000_5555, "R3 resumed");

    // R4 writes ignored without write freeze
    do_write(2'd1, 32'hDEAD_0000);
    do_write(2'd2, 32'h0007_FFFF);
    do_read(2'd1, 32'h0000_5555, "R4 time ignored");
    do_read(2'd2, trim_word(17'h10000, 2'd1), "R4 trim ignored");

    // R4 / R5 / R6 staged write and transfer
    do_write(2'd0, 32'h2);
    do_read(2'd0, 32'h2, "R6 set");
    do_write(2'd1, 32'h00C0_FFEE);
    do_write(2'd2, trim_word(17'h0FFBF, 2'd3));
    do_read(2'd1, 32'h00C0_FFEE, "R4 time staged");
    do_read(2'd2, trim_word(17'h0FFBF, 2'd3), "R4 trim staged");
    live_time = 32'h0000_7777;
    do_tick();
    do_read(2'd1, 32'h00C0_FFEE, "R5 no load while frozen");
    do_write(2'd0, 32'h0);
    do_read(2'd0, 32'h2, "R6 pending after clear");
    expect_load(32'h00C0_FFEE, 17'h0FFBF, 2'd3);
    do_tick();
    do_read(2'd0, 32'h0, "R6 cleared after load");
    do_tick();
    do_read(2'd1, 32'h0000_7777, "R2 tracking after load");

    // R7 failure flag
    @(negedge clk); count_err = 1'b1;
    @(negedge clk); count_err = 1'b0;
    do_read(2'd0, 32'h4, "R7 set by error");
    do_write(2'd0, 32'h4);
    do_read(2'd0, 32'h4, "R7 write one keeps");
    do_write(2'd0, 32'h0);
    do_read(2'd0, 32'h0, "R7 write zero clears");
    @(negedge clk);
    count_err = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0;
    @(negedge clk);
    count_err = 1'b0; reg_we = 1'b0;
    do_read(2'd0, 32'h4, "R7 error beats clear");

    repeat (2) @(negedge clk);
    checks++;
    if (ld_q.size() != 0) begin
      errors++;
      $display("FAIL R5: pending loads=%0d expected=0", ld_q.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule